// File: doc/BRIEF.md
# Receive Channel Reset Sequencer

This block is a synchronous controller that brings a serial transceiver receive channel and its paired transmit channel out of reset after power-up. It steers the receiver clock-data-recovery loop manually. The loop first locks to the reference clock and then to the incoming data. Each handoff is gated by a status input from the reconfiguration logic and by the receiver PLL lock indication. A shared down-counter enforces each timed interval, and every interval length is a parameter counted in clock cycles.

After power-on reset the sequencer holds the PLL in power-down for a fixed width. It then waits for the reconfiguration logic to signal busy, and for busy to clear, before it releases the receive analog reset. It holds reference-clock lock until the receiver PLL has reported lock for a minimum time. It then hands the loop to data lock and, after a further minimum interval, releases the receive digital reset. The transmit digital reset follows its own PLL lock. A done flag reports that the whole channel is up. If the receiver PLL loses lock, the sequence falls back to reference-clock lock.

All pins are plain control and status signals. Nothing streams through the block, so it has no valid/ready interface and no back-pressure.

Top module: `rx_rst_seq`

## Requirements
- R1: While `arst_n` is low, the outputs are held as follows, with no clock edge needed: power-down 1, analog reset 1, receive digital reset 1, transmit digital reset 1, reference lock 1, data lock 0, done 0. The internal reset is released on the second clock edge after `arst_n` rises.
- R2: `pll_pwrdn_o` falls on clock edge PWRDN_CYC+3, counted from the release of `arst_n`. It stays high before that edge.
- R3: After power-down ends, `rx_ana_rst_o` stays high until `busy_i` has been sampled high at least once. It falls on the first later edge at which `busy_i` is sampled low.
- R4: After analog reset release, `lock_ref_o` stays 1, `lock_data_o` stays 0 and `rx_dig_rst_o` stays 1. `lock_ref_o` falls only after `rx_lock_i` has been sampled high on LTR_LTD_CYC+1 consecutive edges, and it falls on the last of those edges.
- R5: `lock_data_o` rises on the same edge that `lock_ref_o` falls. The two outputs are never high together.
- R6: `rx_dig_rst_o` falls LTD_CYC+1 edges after the edge on which `lock_data_o` rose.
- R7: `tx_dig_rst_o` stays high while power-down is active. After that, it falls on the TX_LOCK_CYC-th consecutive edge with `tx_lock_i` sampled high. It rises again after the first edge at which `tx_lock_i` is sampled low.
- R8: If `rx_lock_i` is sampled low while data lock is active, then after that edge `lock_ref_o` is 1, `lock_data_o` is 0 and `rx_dig_rst_o` is 1. The R4 timing then restarts.
- R9: `done_o` is 1 exactly when power-down and all three resets are low and `lock_data_o` is high. Any restart clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| busy_i | input | 1 | Busy status from the reconfiguration logic |
| rx_lock_i | input | 1 | Receiver PLL lock status |
| tx_lock_i | input | 1 | Transmit PLL lock status |
| pll_pwrdn_o | output | 1 | PLL power-down |
| rx_ana_rst_o | output | 1 | Receive analog reset |
| rx_dig_rst_o | output | 1 | Receive digital reset |
| tx_dig_rst_o | output | 1 | Transmit digital reset |
| lock_ref_o | output | 1 | Steer recovery loop to the reference clock |
| lock_data_o | output | 1 | Steer recovery loop to the incoming data |
| done_o | output | 1 | Channel fully out of reset |

## Verification
Every output is decoded from registered state, so a result is due the clock edge after the input that causes it. There are three exceptions. Power-down ends PWRDN_CYC+3 edges after reset release. Reference lock drops LTR_LTD_CYC+1 edges after PLL lock rises. Receive digital reset drops LTD_CYC+1 edges after data lock rises. The bench drives inputs on falling edges and samples on falling edges. It counts the samples in each window and compares the count with a value derived from the parameters, so an off-by-one in any interval shows up as a count mismatch.

// File: rtl/rx_rst_seq_pkg.sv
package rx_rst_seq_pkg;

  typedef enum logic [2:0] {
    ST_PWRDN   = 3'd0,
    ST_BUSY_HI = 3'd1,
    ST_BUSY_LO = 3'd2,
    ST_REF     = 3'd3,
    ST_DATA    = 3'd4,
    ST_RUN     = 3'd5
  } seq_state_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/seq_wait_ctr.sv
module seq_wait_ctr #(
  parameter int W    = 4,
  parameter int INIT = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  localparam logic [W-1:0] INIT_V = INIT[W-1:0];
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= INIT_V;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/seq_tx_gate.sv
module seq_tx_gate #(
  parameter int N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  input  logic lock_i,
  output logic rst_o
);
  localparam int TW = $clog2(N + 1);
  localparam logic [TW-1:0] N_V = N[TW-1:0];
  logic [TW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 run_q <= '0;
    else if (hold_i || !lock_i) run_q <= '0;
    else if (run_q != N_V)      run_q <= run_q + 1'b1;
  end

  assign rst_o = (run_q != N_V);
endmodule

// File: rtl/rx_rst_seq.sv
module rx_rst_seq
  import rx_rst_seq_pkg::*;
#(
  parameter int PWRDN_CYC   = 8,
  parameter int LTR_LTD_CYC = 6,
  parameter int LTD_CYC     = 5,
  parameter int TX_LOCK_CYC = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic busy_i,
  input  logic rx_lock_i,
  input  logic tx_lock_i,
  output logic pll_pwrdn_o,
  output logic rx_ana_rst_o,
  output logic rx_dig_rst_o,
  output logic tx_dig_rst_o,
  output logic lock_ref_o,
  output logic lock_data_o,
  output logic done_o
);
  localparam int CW = $clog2(max3(PWRDN_CYC, LTR_LTD_CYC, LTD_CYC) + 1);
  localparam logic [CW-1:0] LTR_V = LTR_LTD_CYC[CW-1:0];
  localparam logic [CW-1:0] LTD_V = LTD_CYC[CW-1:0];

  logic        rst_n;
  seq_state_t  st_q, st_d;
  logic        wait_zero;
  logic        wait_load;
  logic [CW-1:0] wait_val;
  logic        tx_rst;

  seq_rst_sync #(.STAGES(2)) u_sync (
    .clk(clk), .arst_n(arst_n), .rst_n_o(rst_n)
  );

  seq_wait_ctr #(.W(CW), .INIT(PWRDN_CYC)) u_wait (
    .clk(clk), .rst_n(rst_n), .load_i(wait_load), .val_i(wait_val), .zero_o(wait_zero)
  );

  seq_tx_gate #(.N(TX_LOCK_CYC)) u_tx (
    .clk(clk), .rst_n(rst_n), .hold_i(pll_pwrdn_o), .lock_i(tx_lock_i), .rst_o(tx_rst)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_PWRDN:   if (wait_zero) st_d = ST_BUSY_HI;
      ST_BUSY_HI: if (busy_i) st_d = ST_BUSY_LO;
      ST_BUSY_LO: if (!busy_i) st_d = ST_REF;
      ST_REF:     if (rx_lock_i && wait_zero) st_d = ST_DATA;
      ST_DATA: begin
        if (!rx_lock_i)     st_d = ST_REF;
        else if (wait_zero) st_d = ST_RUN;
      end
      ST_RUN:     if (!rx_lock_i) st_d = ST_REF;
      default:    st_d = ST_PWRDN;
    endcase
  end

  always_comb begin
    wait_load = (st_d != st_q) || (st_q == ST_REF && !rx_lock_i);
    unique case (st_d)
      ST_REF:  wait_val = LTR_V;
      ST_DATA: wait_val = LTD_V;
      default: wait_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_PWRDN;
    else        st_q <= st_d;
  end

  assign pll_pwrdn_o  = (st_q == ST_PWRDN);
  assign rx_ana_rst_o = (st_q == ST_PWRDN) || (st_q == ST_BUSY_HI) || (st_q == ST_BUSY_LO);
  assign rx_dig_rst_o = (st_q != ST_RUN);
  assign lock_data_o  = (st_q == ST_DATA) || (st_q == ST_RUN);
  assign lock_ref_o   = !lock_data_o;
  assign tx_dig_rst_o = tx_rst;
  assign done_o       = (st_q == ST_RUN) && !tx_rst;
endmodule

// File: rtl/rx_rst_seq_chk.sv
module rx_rst_seq_chk (
  input logic clk,
  input logic arst_n,
  input logic busy_i,
  input logic rx_lock_i,
  input logic tx_lock_i,
  input logic pll_pwrdn_o,
  input logic rx_ana_rst_o,
  input logic rx_dig_rst_o,
  input logic tx_dig_rst_o,
  input logic lock_ref_o,
  input logic lock_data_o,
  input logic done_o
);
  AST_ANA_AFTER_IDLE: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(rx_ana_rst_o) |-> !$past(busy_i)); // R3
  AST_REF_HOLDS_DIG: assert property (@(posedge clk) disable iff (!arst_n)
    lock_ref_o |-> rx_dig_rst_o); // R4
  AST_STEER_EXCL: assert property (@(posedge clk) disable iff (!arst_n)
    $onehot0({lock_ref_o, lock_data_o})); // R5
  AST_DIG_NEEDS_DATA: assert property (@(posedge clk) disable iff (!arst_n)
    !rx_dig_rst_o |-> lock_data_o); // R6
  AST_TX_HELD_PWRDN: assert property (@(posedge clk) disable iff (!arst_n)
    pll_pwrdn_o |-> tx_dig_rst_o); // R7
  AST_LOCK_LOSS: assert property (@(posedge clk) disable iff (!arst_n)
    (lock_data_o && !rx_lock_i) |=> (lock_ref_o && rx_dig_rst_o)); // R8
  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!arst_n)
    done_o |-> (!pll_pwrdn_o && !rx_ana_rst_o && !rx_dig_rst_o && !tx_dig_rst_o && lock_data_o)); // R9
endmodule

bind rx_rst_seq rx_rst_seq_chk u_chk (
  .clk(clk), .arst_n(arst_n), .busy_i(busy_i), .rx_lock_i(rx_lock_i),
  .tx_lock_i(tx_lock_i), .pll_pwrdn_o(pll_pwrdn_o), .rx_ana_rst_o(rx_ana_rst_o),
  .rx_dig_rst_o(rx_dig_rst_o), .tx_dig_rst_o(tx_dig_rst_o), .lock_ref_o(lock_ref_o),
  .lock_data_o(lock_data_o), .done_o(done_o)
);

// File: tb/rx_rst_seq_bench.sv
`timescale 1ns/1ps
module rx_rst_seq_bench;
  localparam int PW  = 8;
  localparam int LTR = 6;
  localparam int LTD = 5;
  localparam int TXN = 2;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic busy = 1'b0, rxl = 1'b0, txl = 1'b0;
  logic pwrdn, ana, dig, txr, lref, ldat, done;
  logic [6:0] obs;
  int errs = 0;
  int checks = 0;

  always #4 clk = ~clk;

  rx_rst_seq #(.PWRDN_CYC(PW), .LTR_LTD_CYC(LTR), .LTD_CYC(LTD), .TX_LOCK_CYC(TXN)) u_rx_rst_seq (
    .clk(clk), .arst_n(arst_n), .busy_i(busy), .rx_lock_i(rxl), .tx_lock_i(txl),
    .pll_pwrdn_o(pwrdn), .rx_ana_rst_o(ana), .rx_dig_rst_o(dig), .tx_dig_rst_o(txr),
    .lock_ref_o(lref), .lock_data_o(ldat), .done_o(done)
  );

  // {pwrdn, ana, dig, txr, lref, ldat, done}
  assign obs = {pwrdn, ana, dig, txr, lref, ldat, done};

  // {busy, rx lock, tx lock, hold edges[7:0], expected obs[6:0]}
  localparam int NV = 11;
  localparam logic [17:0] VEC [NV] = '{
    {3'b000, 8'd3,  7'b1111100},  // R1 R2 still powered down
    {3'b001, 8'd12, 7'b0110100},  // R2 R7 waiting for busy, tx up
    {3'b101, 8'd3,  7'b0110100},  // R3 busy seen, analog still held
    {3'b001, 8'd3,  7'b0010100},  // R3 analog released
    {3'b011, 8'd3,  7'b0010100},  // R4 lock too short
    {3'b011, 8'd6,  7'b0010010},  // R5 data lock
    {3'b011, 8'd10, 7'b0000011},  // R6 R9 running
    {3'b001, 8'd2,  7'b0010100},  // R8 lock lost
    {3'b011, 8'd20, 7'b0000011},  // R8 R9 recovered
    {3'b010, 8'd2,  7'b0001010},  // R7 R9 tx lock lost
    {3'b011, 8'd3,  7'b0000011}   // R7 R9 tx back
  };

  task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic chk_n(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start();
    arst_n = 1'b0; busy = 1'b0; rxl = 1'b0; txl = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset state", obs, 7'b1111100);
    arst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 8);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int n;
    @(negedge clk);
    start();
    for (int i = 0; i < NV; i++) begin
      {busy, rxl, txl} = VEC[i][17:15];
      repeat (int'(VEC[i][14:7])) @(negedge clk);
      chk($sformatf("R%0s vector %0d", "1-9", i), obs, VEC[i][6:0]);
    end

    // R2 power-down width
    start();
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!pwrdn) break;
      n++;
    end
    chk_n("R2 pwrdn samples", n, PW + 2);

    // R3 no busy, no release
    repeat (40) @(negedge clk);
    chk("R3 analog held without busy", {6'b0, ana}, 7'd1);
    busy = 1'b1;
    @(negedge clk);
    chk("R3 analog held while busy", {6'b0, ana}, 7'd1);
    busy = 1'b0;
    @(negedge clk);
    chk("R3 analog released", {6'b0, ana}, 7'd0);

    // R4 reference lock window
    rxl = 1'b1;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!lref) break;
      n++;
    end
    chk_n("R4 ref-lock samples", n, LTR);
    chk("R5 data lock with ref drop", {5'b0, lref, ldat}, 7'b0000001);

    // R6 digital reset window
    n = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!dig) break;
      n++;
    end
    chk_n("R6 dig-reset samples after data lock", n, LTD + 1);
    chk("R9 done waits for tx", {6'b0, done}, 7'd0);

    // R7 tx release
    txl = 1'b1;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!txr) break;
      n++;
    end
    chk_n("R7 tx reset samples", n, TXN - 1);
    chk("R9 done set", obs, 7'b0000011);
    txl = 1'b0;
    @(negedge clk);
    chk("R7 tx reset reasserted", {5'b0, txr, done}, 7'b0000010);
    txl = 1'b1;
    repeat (3) @(negedge clk);

    // R8 lock loss from run
    rxl = 1'b0;
    @(negedge clk);
    chk("R8 fallback", obs, 7'b0010100);

    // R1 asynchronous reset mid-run
    rxl = 1'b1;
    repeat (20) @(negedge clk);
    chk("R9 running again", obs, 7'b0000011);
    #2 arst_n = 1'b0;
    #1 chk("R1 async reset", obs, 7'b1111100);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule